// File: doc/BRIEF.md
# Reduced Multiplexer Function Generator

This block is a configurable logic element that evaluates any Boolean function of `N` inputs through a selector with only `2^(N-1)` data legs. A full lookup table would need `2^N` entries. The top `N-1` function inputs steer the selector. Each leg is driven by one of four sources, chosen by a 2-bit code: constant 0, constant 1, the lowest function input, or the complement of that input.

The two truth-table rows that share a select pattern always fall into one of these four cases, so the halved selector still covers every function. A clocked load port writes one leg code per cycle, and the codes are held in registers. The function output is purely combinational from the function inputs and the stored codes.

Top module: `mux_fn_gen`

## Requirements
- R1: The element has `2^(N-1)` legs. The select index is `fn_in[N-1:1]`, with `fn_in[N-1]` as the most significant select bit. `fn_in[0]` is the remaining variable that legs may route.
- R2: A leg holding code `2'b00` drives 0 to `fn_out` while it is selected.
- R3: A leg holding code `2'b01` drives 1 to `fn_out` while it is selected.
- R4: A leg holding code `2'b10` drives `fn_in[0]` to `fn_out` while it is selected.
- R5: A leg holding code `2'b11` drives `~fn_in[0]` to `fn_out` while it is selected.
- R6: When `rst` is high at a rising clock edge, every leg code is cleared to `2'b00`. From the following cycle `fn_out` is 0 for every `fn_in`.
- R7: When `cfg_we` is high at a rising edge and `rst` is low, `cfg_code` is stored into leg `cfg_leg`. The new code governs `fn_out` from the cycle after that edge, and all other legs keep their codes.
- R8: Without a write or reset the codes are held. `fn_out` follows changes of `fn_in` within the same cycle, with no clock edge needed.
- R9: When reset and a write meet at the same edge, reset wins and no leg takes the written code.
- R10: For any truth table, setting leg `i` from rows `2i` and `2i+1` makes `fn_out` equal the table for all inputs. Rows (0,0) give 00, (1,1) give 01, (0,1) give 10 and (1,0) give 11. With N=3 the function true on minterms 0, 2, 6 and 7 uses legs 0..3 set to 11, 11, 00, 01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset, clears all leg codes |
| cfg_we | input | 1 | Leg code write strobe |
| cfg_leg | input | N-1 | Index of the leg being written |
| cfg_code | input | 2 | Source code for the leg being written |
| fn_in | input | N | Function inputs; upper N-1 bits select, bit 0 is routed |
| fn_out | output | 1 | Function value |

## Verification
The function output is due in the same cycle as an input change. The bench applies each input pattern and samples 1 ns later, with no clock edge in between. A leg write or reset is due one cycle after the edge that captures it. Stimulus is driven on the falling edge, so the capturing rising edge always falls between the write and the sweep that checks it. Exhaustive sweeps of all 16 inputs after every single-leg write, and after each loaded truth table, confirm that the written leg changed and that the others did not.

// File: rtl/mfg_pkg.sv
package mfg_pkg;

    typedef enum logic [1:0] {
        LEG_ZERO = 2'b00,
        LEG_ONE  = 2'b01,
        LEG_VAR  = 2'b10,
        LEG_NVAR = 2'b11
    } leg_src_e;

    function automatic logic leg_value(input leg_src_e code, input logic var_bit);
        logic r;
        case (code)
            LEG_ZERO: r = 1'b0;
            LEG_ONE:  r = 1'b1;
            LEG_VAR:  r = var_bit;
            default:  r = ~var_bit;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mfg_cfg_store.sv
module mfg_cfg_store
    import mfg_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_leg,
    input  leg_src_e             wr_code,
    output leg_src_e [(1<<SEL_W)-1:0] codes
);
    localparam int LEGS = 1 << SEL_W;

    for (genvar i = 0; i < LEGS; i++) begin : g_leg
        leg_src_e code_q;
        logic     hit;
        assign hit = wr_en && (wr_leg == SEL_W'(i));
        always_ff @(posedge clk) begin
            if (rst)
                code_q <= LEG_ZERO;
            else if (hit)
                code_q <= wr_code;
        end
        assign codes[i] = code_q;
    end

endmodule

// File: rtl/mfg_leg_resolve.sv
module mfg_leg_resolve
    import mfg_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  leg_src_e [(1<<SEL_W)-1:0] codes,
    input  logic                      var_bit,
    output logic [(1<<SEL_W)-1:0]     legs
);
    localparam int LEGS = 1 << SEL_W;

    for (genvar i = 0; i < LEGS; i++) begin : g_res
        assign legs[i] = leg_value(codes[i], var_bit);
    end

endmodule

// File: rtl/mfg_select_tree.sv
module mfg_select_tree #(
    parameter int SEL_W = 3
) (
    input  logic [(1<<SEL_W)-1:0] legs,
    input  logic [SEL_W-1:0]      sel,
    output logic                  y
);
    for (genvar d = SEL_W; d >= 0; d--) begin : g_lvl
        logic [(1<<d)-1:0] v;
        if (d == SEL_W) begin : g_leaf
            assign v = legs;
        end else begin : g_node
            for (genvar j = 0; j < (1 << d); j++) begin : g_mux
                assign v[j] = sel[SEL_W-1-d] ? g_lvl[d+1].v[2*j+1]
                                              : g_lvl[d+1].v[2*j];
            end
        end
    end

    assign y = g_lvl[0].v[0];

endmodule

// File: rtl/mux_fn_gen.sv
module mux_fn_gen
    import mfg_pkg::*;
#(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic [N-2:0]   cfg_leg,
    input  logic [1:0]     cfg_code,
    input  logic [N-1:0]   fn_in,
    output logic           fn_out
);
    localparam int SEL_W = N - 1;
    localparam int LEGS  = 1 << SEL_W;

    leg_src_e [LEGS-1:0] codes;
    logic     [LEGS-1:0] legs;

    mfg_cfg_store #(.SEL_W(SEL_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we),
        .wr_leg (cfg_leg),
        .wr_code(leg_src_e'(cfg_code)),
        .codes  (codes)
    );

    mfg_leg_resolve #(.SEL_W(SEL_W)) u_resolve (
        .codes  (codes),
        .var_bit(fn_in[0]),
        .legs   (legs)
    );

    mfg_select_tree #(.SEL_W(SEL_W)) u_tree (
        .legs(legs),
        .sel (fn_in[N-1:1]),
        .y   (fn_out)
    );

endmodule

// File: rtl/mux_fn_gen_checker.sv
module mux_fn_gen_checker #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         cfg_we,
    input logic [N-2:0] cfg_leg,
    input logic [1:0]   cfg_code,
    input logic [N-1:0] fn_in,
    input logic         fn_out
);
    localparam int LEGS = 1 << (N - 1);

    logic [1:0]   shadow [LEGS];
    logic [N-2:0] sel;
    logic [1:0]   cur;

    assign sel = fn_in[N-1:1];
    assign cur = shadow[sel];

    always_ff @(posedge clk) begin
        for (int i = 0; i < LEGS; i++) begin
            if (rst)
                shadow[i] <= 2'b00;
            else if (cfg_we && cfg_leg == (N-1)'(i))
                shadow[i] <= cfg_code;
        end
    end

    AST_ZERO_LEG: assert property (@(posedge clk) disable iff (rst)
        cur == 2'b00 |-> !fn_out); // R2
    AST_ONE_LEG: assert property (@(posedge clk) disable iff (rst)
        cur == 2'b01 |-> fn_out); // R3
    AST_VAR_LEG: assert property (@(posedge clk) disable iff (rst)
        cur == 2'b10 |-> fn_out == fn_in[0]); // R4
    AST_NVAR_LEG: assert property (@(posedge clk) disable iff (rst)
        cur == 2'b11 |-> fn_out != fn_in[0]); // R5
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !fn_out); // R6
    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (sel != $past(cfg_leg)) ||
                   (fn_out == (($past(cfg_code) == 2'b01) ||
                               ($past(cfg_code) == 2'b10 && fn_in[0]) ||
                               ($past(cfg_code) == 2'b11 && !fn_in[0])))); // R7
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> ($stable(fn_in) -> $stable(fn_out))); // R8
    AST_RESET_OVER_WRITE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) && $past(cfg_we) |-> !fn_out); // R9

endmodule

bind mux_fn_gen mux_fn_gen_checker #(.N(N)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cfg_we  (cfg_we),
    .cfg_leg (cfg_leg),
    .cfg_code(cfg_code),
    .fn_in   (fn_in),
    .fn_out  (fn_out)
);

// File: tb/mux_fn_gen_bench.sv
`timescale 1ns/1ps
module mux_fn_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_leg = '0;
    logic [1:0] cfg_code = '0;
    logic [3:0] fn_in = '0;
    logic       fn_out;

    logic       s_we = 1'b0;
    logic [1:0] s_leg = '0;
    logic [1:0] s_code = '0;
    logic [2:0] s_in = '0;
    logic       s_out;

    int nchecks = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    mux_fn_gen #(.N(4)) u_mux_fn_gen (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_leg(cfg_leg),
        .cfg_code(cfg_code), .fn_in(fn_in), .fn_out(fn_out)
    );

    mux_fn_gen #(.N(3)) u_mux_fn_gen_n3 (
        .clk(clk), .rst(rst), .cfg_we(s_we), .cfg_leg(s_leg),
        .cfg_code(s_code), .fn_in(s_in), .fn_out(s_out)
    );

    task automatic check(input string req, input logic got, input logic exp, input int pat);
        nchecks++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: input %0d got %b expected %b", req, pat, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic write_leg(input int leg, input logic [1:0] code);
        @(negedge clk);
        cfg_we = 1'b1; cfg_leg = leg[2:0]; cfg_code = code;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic sweep(input logic [15:0] tt, input string req);
        for (int v = 0; v < 16; v++) begin
            fn_in = v[3:0];
            #1;
            check(req, fn_out, tt[v], v);
        end
    endtask

    function automatic logic [1:0] pair_code(input logic r0, input logic r1);
        if (!r0 && !r1) return 2'b00;
        if (r0 && r1)   return 2'b01;
        if (!r0 && r1)  return 2'b10;
        return 2'b11;
    endfunction

    task automatic load_table(input logic [15:0] tt);
        for (int i = 0; i < 8; i++)
            write_leg(i, pair_code(tt[2*i], tt[2*i+1]));
    endtask

    function automatic logic [15:0] single_leg_tt(input int leg, input logic [1:0] code);
        logic [15:0] t = '0;
        for (int v = 0; v < 16; v++) begin
            if ((v >> 1) == leg) begin
                case (code)
                    2'b00: t[v] = 1'b0;
                    2'b01: t[v] = 1'b1;
                    2'b10: t[v] = v[0];
                    default: t[v] = ~v[0];
                endcase
            end
        end
        return t;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchecks + 1);
        $finish;
    end

    initial begin : main
        logic [15:0] tt;
        logic [31:0] seed;
        string req;
        logic [7:0] ex;
        seed = 32'h1234_5678;

        // R6: reset state, output zero everywhere
        do_reset();
        sweep(16'h0000, "R6 reset state");

        // R2..R5, R7: every code on every leg, others stay zero
        for (int k = 0; k < 8; k++) begin
            for (int c = 0; c < 4; c++) begin
                do_reset();
                write_leg(k, c[1:0]);
                case (c)
                    0: req = "R2/R7 zero leg";
                    1: req = "R3/R7 one leg";
                    2: req = "R4/R7 var leg";
                    default: req = "R5/R7 nvar leg";
                endcase
                sweep(single_leg_tt(k, c[1:0]), req);
            end
        end

        // R7: overwrite a leg, other legs keep codes
        do_reset();
        write_leg(2, 2'b01);
        write_leg(5, 2'b10);
        write_leg(2, 2'b11);
        sweep(single_leg_tt(2, 2'b11) | single_leg_tt(5, 2'b10), "R7 overwrite");

        // R1: top input is the select MSB
        do_reset();
        for (int i = 4; i < 8; i++) write_leg(i, 2'b01);
        sweep(16'hFF00, "R1 msb select");

        // R8: combinational response within one cycle
        load_table(16'h6996);
        @(negedge clk);
        fn_in = 4'd3; #1;
        check("R8 same cycle", fn_out, 1'b0, 3);
        fn_in = 4'd7; #0.5;
        check("R8 same cycle", fn_out, 1'b1, 7);
        repeat (3) @(negedge clk);
        sweep(16'h6996, "R8 held codes");

        // R9: reset wins over simultaneous write
        @(negedge clk);
        rst = 1'b1; cfg_we = 1'b1; cfg_leg = 3'd1; cfg_code = 2'b01;
        @(negedge clk);
        rst = 1'b0; cfg_we = 1'b0;
        sweep(16'h0000, "R9 reset priority");

        // R10: fixed and pseudo-random truth tables
        load_table(16'hFFFF); sweep(16'hFFFF, "R10 all ones");
        load_table(16'h0000); sweep(16'h0000, "R10 all zero");
        load_table(16'hA5C3); sweep(16'hA5C3, "R10 mixed");
        for (int n = 0; n < 40; n++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            tt = seed[31:16];
            load_table(tt);
            sweep(tt, "R10 random table");
        end

        // R10: N=3 example, legs 11 11 00 01 give minterms 0,2,6,7
        ex = 8'b1100_0101;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            s_we = 1'b1; s_leg = i[1:0];
            s_code = (i < 2) ? 2'b11 : ((i == 2) ? 2'b00 : 2'b01);
            @(negedge clk);
            s_we = 1'b0;
        end
        for (int v = 0; v < 8; v++) begin
            s_in = v[2:0];
            #1;
            check("R10 n3 example", s_out, ex[v], v);
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end

endmodule